// File: doc/BRIEF.md
# Single-Slope PWM Timer with Two Compare Outputs

The block is an 8-bit up-counter paced by a selectable clock divider. It produces two pulse-width-modulated waveforms, A and B. Each period the counter climbs from zero to a TOP value and then drops back to zero. TOP is either fixed at the full-scale value or taken from compare register A. Each channel compares the counter against its own active compare value. It then sets, clears or toggles its waveform, according to a per-channel output mode.

Software writes new compare values at any time through a shared data bus with one write strobe per channel. A written value waits in a holding register. It becomes active only when the counter passes TOP, so a period never mixes two duty cycles. The block raises three sticky flags: wrap (overflow), match A and match B. Software clears each flag by pulsing its clear input.

Top module: `fpwm_timer`

## Requirements
- R1: Each timer tick advances the counter by one. On the tick where the counter equals TOP, the counter returns to zero. TOP is 0xFF when `wgm_i` is any value other than 7. When `wgm_i` is 7, TOP is the active compare value of channel A.
- R2: `clk_sel_i` picks the tick rate as a division of `clk_i`: 1→/1, 2→/8, 3→/32, 4→/64, 5→/128, 6→/256, 7→/1024. Value 0 stops the counter, and all outputs and flags then hold.
- R3: `ovf_o` becomes 1 on the clock edge where the counter wraps from TOP to zero.
- R4: Output mode 2 (non-inverting): the wave goes to 1 at the wrap and to 0 on a compare match. If both happen on the same tick, the wrap wins. With TOP fixed and compare value C, the wave is high for C+1 of every 256 ticks.
- R5: Output mode 3 (inverting): the wave goes to 0 at the wrap and to 1 on a compare match. If both happen on the same tick, the wrap wins.
- R6: A compare value of 0 in mode 2 gives a pulse one tick wide once per period. A compare value of 0xFF with TOP fixed gives a constant 1 in mode 2 and a constant 0 in mode 3.
- R7: Output mode 1 on channel A with `wgm_i`=7 toggles wave A on every compare match. With compare value 3, this gives a 50% square wave of 8 ticks per cycle.
- R8: Output mode 0 on either channel holds the wave at its current level. So does mode 1 on channel B, and mode 1 on channel A when `wgm_i` is not 7.
- R9: A compare write goes to a holding register. It becomes the active compare value only on the wrap. A write made during a period does not change that period's waveform.
- R10: A channel's match flag becomes 1 on the clock edge of the tick where the counter equals that channel's active compare value.
- R11: Flags stay 1 until their clear input is 1 at a clock edge. If a clear and a set fall on the same edge, the flag is set.
- R12: While `rst_ni` is low, the counter, the compare registers, both waves and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_sel_i | input | 3 | Tick divider select (0 stops the counter) |
| wgm_i | input | 3 | TOP select: 7 uses compare A, other values use 0xFF |
| com_a_i | input | 2 | Output mode of channel A |
| com_b_i | input | 2 | Output mode of channel B |
| ocr_a_we_i | input | 1 | Write strobe for the compare A holding register |
| ocr_b_we_i | input | 1 | Write strobe for the compare B holding register |
| ocr_wdata_i | input | 8 | Compare write data |
| ovf_clr_i | input | 1 | Clears the wrap flag |
| match_a_clr_i | input | 1 | Clears the match A flag |
| match_b_clr_i | input | 1 | Clears the match B flag |
| wave_a_o | output | 1 | Waveform A |
| wave_b_o | output | 1 | Waveform B |
| ovf_o | output | 1 | Wrap flag |
| match_a_o | output | 1 | Match A flag |
| match_b_o | output | 1 | Match B flag |

## Verification
The hardest case to reach is a flag clear that lands on exactly the edge where the flag sets. The bench does not try to find that edge. It holds the clear inputs high for a whole 256-tick period and counts the samples in which each flag reads 1: exactly one means the set won, and zero means the clear won. The buffering check works in a similar way. The bench writes a new compare value on the sample where wave B has just risen. It then measures that period's high time against the next period's high time.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
  typedef enum logic [1:0] {
    COM_OFF    = 2'd0,
    COM_TOGGLE = 2'd1,
    COM_NONINV = 2'd2,
    COM_INV    = 2'd3
  } com_mode_e;

  localparam logic [2:0] WGM_TOP_A = 3'd7;
  localparam int unsigned NCH = 2;
endpackage

// File: rtl/fpwm_prescaler.sv
module fpwm_prescaler #(
  parameter int unsigned PRE_W = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] lim;
  logic             run;

  // divide factor = 2**shift
  always_comb begin
    unique case (sel_i)
      3'd2:    lim = PRE_W'((1 << 3) - 1);
      3'd3:    lim = PRE_W'((1 << 5) - 1);
      3'd4:    lim = PRE_W'((1 << 6) - 1);
      3'd5:    lim = PRE_W'((1 << 7) - 1);
      3'd6:    lim = PRE_W'((1 << 8) - 1);
      3'd7:    lim = PRE_W'((1 << 10) - 1);
      default: lim = '0;
    endcase
  end

  assign run    = (sel_i != 3'd0);
  assign tick_o = run && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + PRE_W'(1);
  end
endmodule

// File: rtl/fpwm_counter.sv
module fpwm_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] top_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_i && (cnt_q == top_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (tick_i)  cnt_q <= wrap_o ? '0 : cnt_q + W'(1);
  end

  a_r1_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wrap_o) |=> cnt_o == $past(cnt_o) + W'(1));
  a_r1_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> cnt_o == '0);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_o));
endmodule

// File: rtl/fpwm_cmp_chan.sv
module fpwm_cmp_chan
  import fpwm_pkg::*;
#(
  parameter int unsigned W         = 8,
  parameter bit          TOGGLE_OK = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         wrap_i,
  input  logic [W-1:0] cnt_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [1:0]   com_i,
  input  logic         toggle_en_i,
  input  logic         clr_i,
  output logic [W-1:0] act_o,
  output logic         wave_o,
  output logic         flag_o
);
  logic [W-1:0] buf_q, act_q;
  logic         wave_q, flag_q, hit;
  com_mode_e    mode;

  assign mode   = com_mode_e'(com_i);
  assign hit    = tick_i && (cnt_i == act_q);
  assign act_o  = act_q;
  assign wave_o = wave_q;
  assign flag_o = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (we_i)   buf_q <= wdata_i;
      if (wrap_i) act_q <= buf_q;
    end
  end

  // wrap has priority over match in PWM modes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wave_q <= 1'b0;
    else begin
      unique case (mode)
        COM_NONINV: begin
          if (wrap_i)   wave_q <= 1'b1;
          else if (hit) wave_q <= 1'b0;
        end
        COM_INV: begin
          if (wrap_i)   wave_q <= 1'b0;
          else if (hit) wave_q <= 1'b1;
        end
        COM_TOGGLE: begin
          if (TOGGLE_OK && toggle_en_i && hit) wave_q <= ~wave_q;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (hit)   flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  a_r10_match_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> flag_o);
  a_r11_match_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
  a_r4_noninv_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && mode == COM_NONINV) |=> wave_o);
  a_r5_inv_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && mode == COM_INV) |=> !wave_o);
  a_r8_off_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == COM_OFF) |=> wave_o == $past(wave_o));
endmodule

// File: rtl/fpwm_timer.sv
module fpwm_timer
  import fpwm_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned PRE_W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [2:0]   clk_sel_i,
  input  logic [2:0]   wgm_i,
  input  logic [1:0]   com_a_i,
  input  logic [1:0]   com_b_i,
  input  logic         ocr_a_we_i,
  input  logic         ocr_b_we_i,
  input  logic [W-1:0] ocr_wdata_i,
  input  logic         ovf_clr_i,
  input  logic         match_a_clr_i,
  input  logic         match_b_clr_i,
  output logic         wave_a_o,
  output logic         wave_b_o,
  output logic         ovf_o,
  output logic         match_a_o,
  output logic         match_b_o
);
  logic                    tick, wrap, ovf_q, top_from_a;
  logic [W-1:0]            cnt, top_val;
  logic [NCH-1:0]          we_v, clr_v, wave_v, flag_v;
  logic [NCH-1:0][1:0]     com_v;
  logic [NCH-1:0][W-1:0]   act_v;

  assign we_v       = {ocr_b_we_i, ocr_a_we_i};
  assign clr_v      = {match_b_clr_i, match_a_clr_i};
  assign com_v[0]   = com_a_i;
  assign com_v[1]   = com_b_i;
  assign top_from_a = (wgm_i == WGM_TOP_A);
  assign top_val    = top_from_a ? act_v[0] : '1;

  fpwm_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (clk_sel_i),
    .tick_o (tick)
  );

  fpwm_counter #(.W(W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .top_i  (top_val),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    fpwm_cmp_chan #(.W(W), .TOGGLE_OK(c == 0)) u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_i      (tick),
      .wrap_i      (wrap),
      .cnt_i       (cnt),
      .we_i        (we_v[c]),
      .wdata_i     (ocr_wdata_i),
      .com_i       (com_v[c]),
      .toggle_en_i (top_from_a),
      .clr_i       (clr_v[c]),
      .act_o       (act_v[c]),
      .wave_o      (wave_v[c]),
      .flag_o      (flag_v[c])
    );

    a_r9_active_loads_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wrap |=> $stable(act_v[c]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (wrap)      ovf_q <= 1'b1;
    else if (ovf_clr_i) ovf_q <= 1'b0;
  end

  assign ovf_o     = ovf_q;
  assign wave_a_o  = wave_v[0];
  assign wave_b_o  = wave_v[1];
  assign match_a_o = flag_v[0];
  assign match_b_o = flag_v[1];

  a_r3_ovf_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> ovf_o);
  a_r11_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);
  a_r12_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> !(ovf_o || wave_a_o || wave_b_o || match_a_o || match_b_o));
endmodule

// File: tb/fpwm_timer_tb.sv
module fpwm_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] clk_sel, wgm;
  logic [1:0] com_a, com_b;
  logic       ocr_a_we, ocr_b_we;
  logic [7:0] ocr_wdata;
  logic       ovf_clr, match_a_clr, match_b_clr;
  logic       wave_a, wave_b, ovf, match_a, match_b;
  int         n_chk = 0;
  int         n_fail = 0;

  always #4 clk = ~clk;

  fpwm_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clk_sel_i(clk_sel), .wgm_i(wgm),
    .com_a_i(com_a), .com_b_i(com_b), .ocr_a_we_i(ocr_a_we), .ocr_b_we_i(ocr_b_we),
    .ocr_wdata_i(ocr_wdata), .ovf_clr_i(ovf_clr), .match_a_clr_i(match_a_clr),
    .match_b_clr_i(match_b_clr), .wave_a_o(wave_a), .wave_b_o(wave_b), .ovf_o(ovf),
    .match_a_o(match_a), .match_b_o(match_b)
  );

  task automatic check_eq(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic sig(int w);
    return (w == 0) ? wave_a : wave_b;
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int ch, int v);
    @(negedge clk);
    if (ch == 0) ocr_a_we = 1'b1; else ocr_b_we = 1'b1;
    ocr_wdata = v[7:0];
    @(negedge clk);
    ocr_a_we = 1'b0;
    ocr_b_we = 1'b0;
  endtask

  task automatic wait_rise(int w, int limit, output int cyc);
    logic prev = sig(w);
    cyc = -1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (!prev && sig(w)) begin cyc = i; return; end
      prev = sig(w);
    end
  endtask

  task automatic wait_fall(int w, int limit);
    logic prev = sig(w);
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (prev && !sig(w)) return;
      prev = sig(w);
    end
  endtask

  task automatic count_high(int w, int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      if (sig(w)) h++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check_eq("R12", "outputs in reset", {wave_a, wave_b, ovf, match_a, match_b}, 0);
    @(negedge clk) rst_n = 1'b1;
    step(300);
    check_eq("R2", "stopped: outputs and flags", {wave_a, wave_b, ovf, match_a, match_b}, 0);
  endtask

  task automatic t_pwm_basic();
    int c, h;
    clk_sel = 3'd1; wgm = 3'd3; com_a = 2'd3; com_b = 2'd2;
    wr(0, 63); wr(1, 63);
    step(600);
    wait_rise(1, 600, c);
    wait_rise(1, 600, c);
    check_eq("R1", "period at fixed TOP", c, 256);
    count_high(1, 256, h);
    check_eq("R4", "non-inverted high ticks", h, 64);
    wait_rise(0, 600, c);
    count_high(0, 256, h);
    check_eq("R5", "inverted high ticks", h, 192);
    wait_rise(1, 600, c);
    step(10);
    @(negedge clk); ovf_clr = 1'b1; match_b_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0; match_b_clr = 1'b0;
    check_eq("R11", "flags cleared", {ovf, match_b}, 0);
    wait_fall(1, 300);
    check_eq("R10", "match B at falling edge", match_b, 1);
    check_eq("R3", "ovf before wrap", ovf, 0);
    wait_rise(1, 300, c);
    check_eq("R3", "ovf at wrap", ovf, 1);
  endtask

  task automatic t_collision();
    int no = 0, nm = 0;
    @(negedge clk); ovf_clr = 1'b1; match_b_clr = 1'b1;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (ovf) no++;
      if (match_b) nm++;
    end
    ovf_clr = 1'b0; match_b_clr = 1'b0;
    check_eq("R11", "ovf set wins over held clear", no, 1);
    check_eq("R11", "match B set wins over held clear", nm, 1);
  endtask

  task automatic t_buffer();
    int c, h = 0;
    wait_rise(1, 600, c);
    ocr_b_we = 1'b1; ocr_wdata = 8'd200;
    for (int i = 0; i < 256; i++) begin
      if (wave_b) h++;
      @(negedge clk);
      ocr_b_we = 1'b0;
    end
    check_eq("R9", "period of write keeps old duty", h, 64);
    count_high(1, 256, h);
    check_eq("R9", "next period uses new duty", h, 201);
  endtask

  task automatic t_extremes();
    int c, h;
    wr(1, 0); wr(0, 255);
    step(600);
    wait_rise(1, 600, c);
    count_high(1, 256, h);
    check_eq("R6", "compare 0 spike width", h, 1);
    wr(1, 255);
    step(600);
    count_high(1, 512, h);
    check_eq("R6", "compare 0xFF non-inverted", h, 512);
    count_high(0, 512, h);
    check_eq("R6", "compare 0xFF inverted", h, 0);
  endtask

  task automatic t_top_a();
    int c, h;
    wgm = 3'd7; com_a = 2'd0;
    wr(0, 99); wr(1, 49);
    step(600);
    wait_rise(1, 600, c);
    wait_rise(1, 600, c);
    check_eq("R1", "period with TOP from A", c, 100);
    count_high(1, 100, h);
    check_eq("R1", "high ticks with TOP from A", h, 50);
  endtask

  task automatic t_toggle_prescale();
    int c, h;
    int divs[7] = '{1, 8, 32, 64, 128, 256, 1024};
    clk_sel = 3'd1; com_a = 2'd1;
    wr(0, 3);
    step(300);
    wait_rise(0, 100, c);
    count_high(0, 8, h);
    check_eq("R7", "toggle high ticks", h, 4);
    for (int s = 1; s <= 7; s++) begin
      clk_sel = 3'(s);
      wait_rise(0, 20000, c);
      wait_rise(0, 20000, c);
      wait_rise(0, 20000, c);
      check_eq("R2", $sformatf("toggle cycle, sel %0d", s), c, 8 * divs[s-1]);
    end
  endtask

  task automatic t_hold();
    int c, h;
    clk_sel = 3'd1; wgm = 3'd3; com_a = 2'd2; com_b = 2'd2;
    wr(0, 127); wr(1, 127);
    step(600);
    wait_fall(1, 600);
    com_b = 2'd1;
    count_high(1, 600, h);
    check_eq("R8", "mode 1 on B holds", h, 0);
    wait_fall(0, 600);
    com_a = 2'd1;
    count_high(0, 600, h);
    check_eq("R8", "mode 1 on A without TOP from A holds", h, 0);
    com_a = 2'd2;
    wait_rise(0, 600, c);
    com_a = 2'd0;
    count_high(0, 600, h);
    check_eq("R8", "mode 0 holds", h, 600);
    clk_sel = 3'd0;
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    step(600);
    check_eq("R2", "stopped: no wrap flag", ovf, 0);
    check_eq("R2", "stopped: wave A holds", wave_a, 1);
  endtask

  initial begin
    #(8 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clk_sel = '0; wgm = '0; com_a = '0; com_b = '0;
    ocr_a_we = 1'b0; ocr_b_we = 1'b0; ocr_wdata = '0;
    ovf_clr = 1'b0; match_a_clr = 1'b0; match_b_clr = 1'b0;
    step(3);
    t_reset();
    t_pwm_basic();
    t_collision();
    t_buffer();
    t_extremes();
    t_top_a();
    t_toggle_prescale();
    t_hold();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule